// File: doc/BRIEF.md
# Power-Mode-Gated Watchdog Timer

This block is a watchdog for a small controller subsystem. A counter advances once per machine cycle, marked by a one-clock enable. If software fails to restart it before it reaches a terminal count, the block drives a reset pulse of fixed length to the rest of the system. A 3-bit select code chooses one of eight terminal counts, each of the form 2^N − 1 machine cycles, with N rising by one for each step of the code. A restart takes two writes to a restart port, and the watchdog stays disarmed after hardware reset until the first such restart.

Counting depends on the power state. In power-down the clock is modelled as stopped, so the count holds and cannot expire. When the system wakes from power-down by a level-sensitive, active-low interrupt, counting stays suspended for as long as that line is held low, and resumes once it returns high. Idle mode has no effect on the counter, so software must keep servicing it.

Top module: `pm_watchdog`

## Requirements
- R1: After hardware reset `wdt_rst` is low, the watchdog is disarmed, and no reset pulse occurs for any number of cycles until a valid restart sequence arrives.
- R2: After a restart with code c, the pulse starts after exactly 2^(BASE_LOG2+c) − 1 counted machine cycles: with `mc_tick` held high and the restart's second write captured at edge E0, `wdt_rst` is low after edge E(T−1) and high after edge ET.
- R3: A write to the select port stores only bits [2:0] of `sel_wdata`, bits [7:3] are discarded, the stored code is visible on `sel_code` from the next cycle, and it resets to 000 (the shortest timeout).
- R4: A restart is a write of 8'h1E followed, as the next write on the restart port, by 8'h E1 (8'hE1); it clears the count to zero and arms the watchdog.
- R5: Any other sequence of restart writes (a lone 8'hE1, 8'h1E followed by another value, reversed order) leaves the count unchanged.
- R6: The reset pulse lasts exactly PULSE_LEN (96) clock cycles; at its end the count is zero, the watchdog stays armed, and the next pulse follows after another full timeout.
- R7: A select change while counting applies to the current count without clearing it; if the count already meets the new terminal value, the pulse starts on the next counted cycle.
- R8: While `pd_mode` is high the count holds its value and no pulse can start, however long power-down lasts.
- R9: If `wake_n` is low during power-down, counting stays suspended after `pd_mode` falls until the cycle after `wake_n` is seen high.
- R10: `idle_mode` does not stop counting, and a low `wake_n` outside power-down has no effect on the count.
- R11: A hardware reset during counting or during a pulse ends the pulse, disarms the watchdog and restores code 000.
- R12: Only cycles with `mc_tick` high advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mc_tick | input | 1 | Machine-cycle enable, one clock per machine cycle |
| sel_we | input | 1 | Write strobe for the timeout select register |
| sel_wdata | input | 8 | Select write data; bits [2:0] are the code |
| sel_code | output | 3 | Stored timeout select code |
| svc_we | input | 1 | Write strobe for the restart register |
| svc_wdata | input | 8 | Restart write data |
| pd_mode | input | 1 | Power-down active |
| idle_mode | input | 1 | Idle active |
| wake_n | input | 1 | Level-sensitive active-low wake interrupt |
| wdt_rst | output | 1 | System reset pulse |

## Verification
A counter that is off by a cycle, cleared at the wrong moment, or left running in power-down shows up as `wdt_rst` rising one or more cycles away from its predicted edge, so every timing check samples both the cycle before and the cycle of the expected rise. A wrong arming or unlock state shows as a pulse that appears during a quiet window or fails to appear a full timeout later. A stuck hold flag shows as a delayed rise measured from the release of `wake_n`, and a broken pulse counter shows at the 96th cycle after the rise.

// File: rtl/pm_wdog_pkg.sv
// Shared constants for the power-mode-gated watchdog.
// Assumes an 8-bit register write data path.
package pm_wdog_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned SEL_W  = 3;
    localparam logic [REG_W-1:0] UNLOCK_FIRST  = 8'h1E;
    localparam logic [REG_W-1:0] UNLOCK_SECOND = 8'hE1;
endpackage

// File: rtl/pm_wdog_unlock.sv
// Restart-sequence detector: flags a restart when the first key is
// followed, as the very next write, by the second key.
// Assumes writes are single-cycle strobes; idle cycles between writes
// do not break the sequence.
module pm_wdog_unlock
    import pm_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             svc_ok
);
    logic stage_q;

    // Remember whether the most recent write was the first key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
        end else if (wr_en) begin
            stage_q <= (wr_data == UNLOCK_FIRST);
        end
    end

    // A restart is the second key arriving while the first is pending.
    always_comb begin
        svc_ok = wr_en && stage_q && (wr_data == UNLOCK_SECOND);
    end
endmodule

// File: rtl/pm_wdog_gate.sv
// Power-mode gate: decides on which clocks the watchdog may count.
// Freezes during power-down and holds off after an interrupt wake
// until the wake line is released. Idle does not gate counting.
module pm_wdog_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic mc_tick,
    input  logic pd_mode,
    input  logic idle_mode,
    input  logic wake_n,
    output logic count_en
);
    logic hold_q;

    // Latch a wake request seen in power-down until the line goes high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= (pd_mode || hold_q) && !wake_n;
        end
    end

    // Count only armed machine cycles outside power-down and wake hold.
    always_comb begin
        count_en = armed && mc_tick && !pd_mode && !hold_q;
    end

    // R9: a wake seen in power-down keeps counting off while the line stays low.
    p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_mode) && !$past(wake_n) && !wake_n) |-> !count_en);

    // R10: idle never suppresses counting.
    p_idle_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode && !pd_mode && !hold_q && armed && mc_tick) |-> count_en);
endmodule

// File: rtl/pm_wdog_core.sv
// Watchdog counter and reset pulse generator. Terminal counts are
// 2^(BASE_LOG2+code)-1 counted cycles; on expiry a PULSE_LEN-clock
// pulse is driven, after which the count restarts from zero.
// Assumes count_en is already gated by arming and power mode.
module pm_wdog_core
    import pm_wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 14,
    parameter int unsigned PULSE_LEN = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             svc_ok,
    input  logic [SEL_W-1:0] sel,
    output logic             armed,
    output logic             wdt_rst
);
    localparam int unsigned SEL_N  = 1 << SEL_W;
    localparam int unsigned CNT_W  = BASE_LOG2 + SEL_N - 1;
    localparam int unsigned PCNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              pulse_q;
    logic              armed_q;
    logic [CNT_W:0]    last_before [SEL_N];
    logic              fire;
    logic              pulse_end;

    // One-less-than-terminal value for each select code.
    for (genvar g = 0; g < SEL_N; g++) begin : g_term
        assign last_before[g] = (CNT_W+1)'((64'd1 << (BASE_LOG2 + g)) - 64'd2);
    end

    // Expiry on the counted cycle that reaches the terminal value.
    always_comb begin
        fire      = count_en && !pulse_q && ({1'b0, cnt_q} >= last_before[sel]);
        pulse_end = pulse_q && (pcnt_q == PCNT_W'(PULSE_LEN - 1));
    end

    // Arming: set by the first restart, cleared only by hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (svc_ok) begin
            armed_q <= 1'b1;
        end
    end

    // Main count: restart and pulse end clear it, pulse freezes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (svc_ok || pulse_end) begin
            cnt_q <= '0;
        end else if (count_en && !pulse_q && !fire) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Pulse generator: fixed-length reset output after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (fire) begin
            pulse_q <= 1'b1;
            pcnt_q  <= '0;
        end else if (pulse_end) begin
            pulse_q <= 1'b0;
        end else if (pulse_q) begin
            pcnt_q <= pcnt_q + PCNT_W'(1);
        end
    end

    assign armed   = armed_q;
    assign wdt_rst = pulse_q;

    // R4: a restart leaves the count at zero and the watchdog armed.
    p_svc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt_q == '0) && armed_q);

    // R1: no pulse while disarmed.
    p_disarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !wdt_rst);

    // R6: the count is zero when the pulse ends.
    p_restart_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst) |-> (cnt_q == '0));

    // R6: a pulse never lasts a single clock.
    p_pulse_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |=> wdt_rst);
endmodule

// File: rtl/pm_watchdog.sv
// Top level: timeout select register, restart detector, power-mode
// gate and counter core. Assumes a synchronous active-low reset and
// a machine-cycle enable from the surrounding clocking logic.
module pm_watchdog
    import pm_wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 14,
    parameter int unsigned PULSE_LEN = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             sel_we,
    input  logic [REG_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_code,
    input  logic             svc_we,
    input  logic [REG_W-1:0] svc_wdata,
    input  logic             pd_mode,
    input  logic             idle_mode,
    input  logic             wake_n,
    output logic             wdt_rst
);
    logic [SEL_W-1:0] sel_q;
    logic             svc_ok;
    logic             armed;
    logic             count_en;
    logic             sel_hi_unused;

    assign sel_hi_unused = ^sel_wdata[REG_W-1:SEL_W];

    // Timeout select register; reserved upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata[SEL_W-1:0];
        end
    end

    assign sel_code = sel_q;

    pm_wdog_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (svc_we),
        .wr_data (svc_wdata),
        .svc_ok  (svc_ok)
    );

    pm_wdog_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .mc_tick   (mc_tick),
        .pd_mode   (pd_mode),
        .idle_mode (idle_mode),
        .wake_n    (wake_n),
        .count_en  (count_en)
    );

    pm_wdog_core #(
        .BASE_LOG2 (BASE_LOG2),
        .PULSE_LEN (PULSE_LEN)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .svc_ok   (svc_ok),
        .sel      (sel_q),
        .armed    (armed),
        .wdt_rst  (wdt_rst)
    );

    // R3: a select write shows its low bits on the next cycle.
    p_sel_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_code == $past(sel_wdata[SEL_W-1:0])));

    // R8: no pulse can begin out of a power-down cycle.
    p_no_fire_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_mode |=> !$rose(wdt_rst));
endmodule

// File: tb/pm_watchdog_bench.sv
module pm_watchdog_bench;
    localparam int BASE = 4;
    localparam int PLEN = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b1;
    logic       sel_we = 1'b0;
    logic [7:0] sel_wdata = 8'h00;
    logic [2:0] sel_code;
    logic       svc_we = 1'b0;
    logic [7:0] svc_wdata = 8'h00;
    logic       pd_mode = 1'b0;
    logic       idle_mode = 1'b0;
    logic       wake_n = 1'b1;
    logic       wdt_rst;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pm_watchdog #(.BASE_LOG2(BASE), .PULSE_LEN(PLEN)) u_pm_watchdog (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_code(sel_code),
        .svc_we(svc_we), .svc_wdata(svc_wdata),
        .pd_mode(pd_mode), .idle_mode(idle_mode), .wake_n(wake_n),
        .wdt_rst(wdt_rst)
    );

    // Stimulus table: select byte written, expected code, expected timeout.
    localparam logic [7:0] V_BYTE [8] = '{8'h00, 8'hF9, 8'h02, 8'h0B, 8'h84, 8'h05, 8'h56, 8'hFF};
    localparam logic [2:0] V_CODE [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int         V_TERM [8] = '{15, 31, 63, 127, 255, 511, 1023, 2047};

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: wdt_rst=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_sel(input string req, input logic [2:0] exp);
        n_vec++;
        if (sel_code !== exp) begin
            n_bad++;
            $display("FAIL %s: sel_code=%0d expected %0d", req, sel_code, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel_we = 1'b0; svc_we = 1'b0; pd_mode = 1'b0;
        idle_mode = 1'b0; wake_n = 1'b1; mc_tick = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
    endtask

    task automatic svc_wr(input logic [7:0] b);
        svc_we = 1'b1; svc_wdata = b;
        @(negedge clk);
    endtask

    // Valid restart; returns just after the edge that captured the second key.
    task automatic service();
        svc_wr(8'h1E);
        svc_wr(8'hE1);
        svc_we = 1'b0;
    endtask

    task automatic write_sel(input logic [7:0] b);
        sel_we = 1'b1; sel_wdata = b;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    // Watches for any pulse over a window; used for quiet checks.
    task automatic quiet(input string req, input int n);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (wdt_rst === 1'b1) seen = 1'b1;
        end
        chk(req, seen, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 R3: reset state
        do_reset();
        @(negedge clk);
        chk("R1 reset output", wdt_rst, 1'b0);
        chk_sel("R3 reset code", 3'd0);
        quiet("R1 disarmed", 60);

        // R2 R3: default code gives shortest timeout
        service();
        wait_n(14); chk("R2 default T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R2 default T", wdt_rst, 1'b1);
        wait_n(96);

        // Table walk: R2 R3 R6
        for (int i = 0; i < 8; i++) begin
            write_sel(V_BYTE[i]);
            chk_sel("R3 select store", V_CODE[i]);
            service();
            wait_n(V_TERM[i] - 1); chk("R2 before expiry", wdt_rst, 1'b0);
            wait_n(1);             chk("R2 at expiry", wdt_rst, 1'b1);
            wait_n(PLEN - 1);      chk("R6 last pulse cycle", wdt_rst, 1'b1);
            wait_n(1);             chk("R6 pulse ended", wdt_rst, 1'b0);
            if (i == 0) begin
                wait_n(V_TERM[i] - 1); chk("R6 rearmed before", wdt_rst, 1'b0);
                wait_n(1);             chk("R6 rearmed fires", wdt_rst, 1'b1);
                wait_n(PLEN);
            end
        end

        // R5: broken sequences do not restart
        do_reset();
        service();
        svc_wr(8'hE1); svc_wr(8'h1E); svc_wr(8'h00); svc_wr(8'hE1);
        svc_we = 1'b0;
        wait_n(10); chk("R5 no restart T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R5 no restart T", wdt_rst, 1'b1);

        // R7: shrink timeout under a running count
        do_reset();
        write_sel(8'h03);
        service();
        wait_n(40);
        write_sel(8'h01);
        chk("R7 shrink before", wdt_rst, 1'b0);
        wait_n(1); chk("R7 shrink fires", wdt_rst, 1'b1);

        // R7: grow timeout keeps the count
        do_reset();
        service();
        wait_n(10);
        write_sel(8'h01);
        wait_n(19); chk("R7 grow T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R7 grow T", wdt_rst, 1'b1);

        // R8: power-down freeze
        do_reset();
        service();
        wait_n(5);
        pd_mode = 1'b1;
        wait_n(50); chk("R8 no expiry in pd", wdt_rst, 1'b0);
        pd_mode = 1'b0;
        wait_n(9); chk("R8 resume T-1", wdt_rst, 1'b0);
        wait_n(1); chk("R8 resume T", wdt_rst, 1'b1);

        // R9: interrupt wake holds counting until line high
        do_reset();
        service();
        wait_n(5);
        pd_mode = 1'b1;
        wait_n(10);
        wake_n = 1'b0;
        wait_n(5);
        pd_mode = 1'b0;
        wait_n(30); chk("R9 held while low", wdt_rst, 1'b0);
        wake_n = 1'b1;
        wait_n(10); chk("R9 release T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R9 release T", wdt_rst, 1'b1);

        // R10: idle and stray wake do not stop counting
        do_reset();
        service();
        idle_mode = 1'b1; wake_n = 1'b0;
        wait_n(14); chk("R10 idle T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R10 idle T", wdt_rst, 1'b1);

        // R12: only machine cycles count
        do_reset();
        service();
        mc_tick = 1'b0;
        wait_n(20);
        mc_tick = 1'b1;
        wait_n(14); chk("R12 tick T-1", wdt_rst, 1'b0);
        wait_n(1);  chk("R12 tick T", wdt_rst, 1'b1);

        // R11: reset mid-count and mid-pulse
        do_reset();
        write_sel(8'h02);
        service();
        wait_n(10);
        do_reset();
        @(negedge clk);
        chk_sel("R11 code restored", 3'd0);
        quiet("R11 disarmed after reset", 70);
        service();
        wait_n(15); chk("R11 pulse started", wdt_rst, 1'b1);
        do_reset();
        chk("R11 pulse cut", wdt_rst, 1'b0);
        quiet("R11 quiet after cut", 40);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule